// File: doc/BRIEF.md
# Predictive Block Migration Controller for a Banked Shared Cache

This controller manages where cache blocks live inside a shared second-level cache. The cache is built from a row of bank columns. Column 0 sits next to the cores that share the cache, and the highest column is the farthest away. For every resident block the controller keeps a small table entry: a valid bit, the block address, the column and way that hold it, and a 2-bit saturating migration counter. Each column also keeps a recency rank for each of its ways.

A core presents one block address per access. On a miss, the controller requests the block from off-chip memory and places it in the farthest column, replacing the least recently used way there. When a block is accessed often enough, it is moved one column closer, trading places with the least recently used block in the destination column. After the accessed block is handled, the controller looks up the block with the next address. If that block is already on chip and not yet in the nearest column, it receives the same count-and-move treatment. The block is then moved toward the core before that core asks for it.

The controller does not move data itself. It issues fill and move commands, each with a block address, a source column and a destination column, over a valid/ack handshake. It accepts a new access only when every command of the previous access has been acknowledged. The FSM states are:
- ST_IDLE: waits for a request.
- ST_LOOK_A: looks up the accessed block. A hit goes to ST_BUMP_A and a miss goes to ST_FILL.
- ST_FILL: waits for the fill ack, then goes to ST_BUMP_A.
- ST_BUMP_A: advances the accessed block's counter. On saturation it goes to ST_MOVE_A, otherwise to ST_LOOK_B.
- ST_MOVE_A: waits for the move ack, then goes to ST_LOOK_B.
- ST_LOOK_B: looks up the next block. If that block is resident and not in column 0 it goes to ST_BUMP_B, otherwise to ST_IDLE.
- ST_BUMP_B: advances the next block's counter. On saturation it goes to ST_MOVE_B, otherwise to ST_IDLE.
- ST_MOVE_B: waits for the move ack, then goes to ST_IDLE.

Top module: `nm_mig_ctrl`

## Requirements
- R1: `req_ready` is high only in ST_IDLE. An access is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until every command of that access has been acknowledged.
- R2: An access whose block is not resident issues exactly one fill command. A fill has `cmd_kind`=1, the accessed address, and source and destination column both equal to the farthest column (7). The filled block counts that access as its first.
- R3: Each access to a resident block outside column 0 advances its 2-bit counter. The increment that would reach 3 issues a move command with `cmd_kind`=0, source column c and destination c-1, and clears the counter. A freshly filled block therefore moves on its third access.
- R4: A block in column 0 never produces a move command, whether it is the accessed block or the next block.
- R5: After the accessed block A is handled, block A+1 is looked up. If A+1 is resident outside column 0, it gets the same counter and move rule. A's command is always issued before A+1's command.
- R6: A next block that is not resident causes no fill or any other command.
- R7: A fill goes into an invalid way of column 7 if there is one. Otherwise it goes into the least recently used way, and the block there is evicted. A later access to the evicted block misses again.
- R8: A move exchanges the moving block with the destination column's invalid or least recently used way. The displaced block goes to the source column and stays resident with its counter unchanged.
- R9: A hit on the accessed block, a fill, and a move's arrival each make that block the most recent in its column. The lookup of the next block does not.
- R10: While `cmd_valid` is high and `cmd_ack` is low, the command fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Block address of the access |
| req_ready | output | 1 | Controller idle, access can be taken |
| cmd_valid | output | 1 | Command present |
| cmd_kind | output | 1 | 0 = move one column inward, 1 = fill from off-chip |
| cmd_addr | output | ADDR_W | Block address the command concerns |
| cmd_src_col | output | COL_W | Source column (farthest column for a fill) |
| cmd_dst_col | output | COL_W | Destination column |
| cmd_ack | input | 1 | Command completed |

## Verification
Two functions can fall in the same access: the accessed block saturates and moves, and the next-address block also saturates and moves. To provoke this, two neighbouring blocks are filled and the lower one is accessed twice more, so both counters reach the limit on the same access. The scoreboard then expects the lower block's move first and the upper block's move second, both from column 7 to column 6. A related pairing is the eviction of a move victim, which must leave the victim resident one column outward. A later access that hits without any fill command shows this.

// File: rtl/nm_pkg.sv
package nm_pkg;

    typedef enum logic {
        CMD_MOVE = 1'b0,
        CMD_FILL = 1'b1
    } nm_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK_A,
        ST_FILL,
        ST_BUMP_A,
        ST_MOVE_A,
        ST_LOOK_B,
        ST_BUMP_B,
        ST_MOVE_B
    } nm_state_e;

endpackage

// File: rtl/nm_match.sv
module nm_match #(
    parameter int COLS   = 8,
    parameter int WAYS   = 2,
    parameter int ADDR_W = 16,
    localparam int COL_W = $clog2(COLS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              vld  [COLS][WAYS],
    input  logic [ADDR_W-1:0] tag  [COLS][WAYS],
    input  logic [ADDR_W-1:0] key,
    output logic              hit,
    output logic [COL_W-1:0]  col,
    output logic [WAY_W-1:0]  way
);

    always_comb begin
        hit = 1'b0;
        col = '0;
        way = '0;
        for (int c = 0; c < COLS; c++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (vld[c][w] && (tag[c][w] == key)) begin
                    hit = 1'b1;
                    col = COL_W'(c);
                    way = WAY_W'(w);
                end
            end
        end
    end

endmodule

// File: rtl/nm_victim.sv
module nm_victim #(
    parameter int WAYS = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             vld [WAYS],
    input  logic [WAY_W-1:0] age [WAYS],
    output logic [WAY_W-1:0] way
);

    logic found;

    always_comb begin
        found = 1'b0;
        way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vld[w] && !found) begin
                found = 1'b1;
                way   = WAY_W'(w);
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age[w] == WAY_W'(WAYS - 1)) begin
                    way = WAY_W'(w);
                end
            end
        end
    end

endmodule

// File: rtl/nm_mig_ctrl.sv
module nm_mig_ctrl
    import nm_pkg::*;
#(
    parameter int COLS   = 8,
    parameter int WAYS   = 2,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 2,
    localparam int COL_W = $clog2(COLS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              cmd_valid,
    output logic              cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [COL_W-1:0]  cmd_src_col,
    output logic [COL_W-1:0]  cmd_dst_col,
    input  logic              cmd_ack
);

    localparam int CNT_MAX = (1 << CNT_W) - 1;
    localparam logic [COL_W-1:0] FAR_COL = COL_W'(COLS - 1);

    nm_state_e state_q, state_d;

    logic              vld_q  [COLS][WAYS];
    logic [ADDR_W-1:0] tag_q  [COLS][WAYS];
    logic [CNT_W-1:0]  cnt_q  [COLS][WAYS];
    logic [WAY_W-1:0]  age_q  [COLS][WAYS];

    logic [ADDR_W-1:0] acc_addr_q;
    logic [COL_W-1:0]  cur_col_q;
    logic [WAY_W-1:0]  cur_way_q;

    logic [ADDR_W-1:0] look_key;
    logic              m_hit;
    logic [COL_W-1:0]  m_col;
    logic [WAY_W-1:0]  m_way;
    logic [WAY_W-1:0]  vic_way [COLS];

    logic [CNT_W-1:0]  cur_cnt;
    logic              sat_next;
    logic [COL_W-1:0]  dst_col;
    logic [WAY_W-1:0]  dst_way;
    logic              is_move;

    logic              touch_en;
    logic [COL_W-1:0]  touch_col;
    logic [WAY_W-1:0]  touch_way;

    assign look_key = (state_q == ST_LOOK_B) ? acc_addr_q + 1'b1 : acc_addr_q;
    assign cur_cnt  = cnt_q[cur_col_q][cur_way_q];
    assign sat_next = (cur_cnt == CNT_W'(CNT_MAX - 1));
    assign dst_col  = cur_col_q - 1'b1;
    assign dst_way  = vic_way[dst_col];
    assign is_move  = (state_q == ST_MOVE_A) || (state_q == ST_MOVE_B);

    nm_match #(
        .COLS   (COLS),
        .WAYS   (WAYS),
        .ADDR_W (ADDR_W)
    ) u_match (
        .vld (vld_q),
        .tag (tag_q),
        .key (look_key),
        .hit (m_hit),
        .col (m_col),
        .way (m_way)
    );

    for (genvar gc = 0; gc < COLS; gc++) begin : g_vic
        nm_victim #(
            .WAYS (WAYS)
        ) u_vic (
            .vld (vld_q[gc]),
            .age (age_q[gc]),
            .way (vic_way[gc])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOK_A;
            ST_LOOK_A: state_d = m_hit ? ST_BUMP_A : ST_FILL;
            ST_FILL:   if (cmd_ack) state_d = ST_BUMP_A;
            ST_BUMP_A: begin
                if (cur_col_q == '0) state_d = ST_LOOK_B;
                else if (sat_next)   state_d = ST_MOVE_A;
                else                 state_d = ST_LOOK_B;
            end
            ST_MOVE_A: if (cmd_ack) state_d = ST_LOOK_B;
            ST_LOOK_B: state_d = (m_hit && (m_col != '0)) ? ST_BUMP_B : ST_IDLE;
            ST_BUMP_B: state_d = sat_next ? ST_MOVE_B : ST_IDLE;
            ST_MOVE_B: if (cmd_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        cmd_valid   = 1'b0;
        cmd_kind    = CMD_MOVE;
        cmd_addr    = tag_q[cur_col_q][cur_way_q];
        cmd_src_col = cur_col_q;
        cmd_dst_col = dst_col;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_FILL: begin
                cmd_valid   = 1'b1;
                cmd_kind    = CMD_FILL;
                cmd_addr    = acc_addr_q;
                cmd_src_col = FAR_COL;
                cmd_dst_col = FAR_COL;
            end
            ST_MOVE_A, ST_MOVE_B: cmd_valid = 1'b1;
            ST_LOOK_A, ST_BUMP_A, ST_LOOK_B, ST_BUMP_B: begin
            end
            default: begin
            end
        endcase
    end

    // recency touch request
    always_comb begin
        touch_en  = 1'b0;
        touch_col = m_col;
        touch_way = m_way;
        if ((state_q == ST_LOOK_A) && m_hit) begin
            touch_en = 1'b1;
        end else if ((state_q == ST_FILL) && cmd_ack) begin
            touch_en  = 1'b1;
            touch_col = FAR_COL;
            touch_way = vic_way[FAR_COL];
        end else if (is_move && cmd_ack) begin
            touch_en  = 1'b1;
            touch_col = dst_col;
            touch_way = dst_way;
        end
    end

    // recency ranks, kept per slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < COLS; c++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[c][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[touch_col][w] <= '0;
                end else if (age_q[touch_col][w] < age_q[touch_col][touch_way]) begin
                    age_q[touch_col][w] <= age_q[touch_col][w] + 1'b1;
                end
            end
        end
    end

    // location table and access context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_addr_q <= '0;
            cur_col_q  <= '0;
            cur_way_q  <= '0;
            for (int c = 0; c < COLS; c++) begin
                for (int w = 0; w < WAYS; w++) begin
                    vld_q[c][w] <= 1'b0;
                    tag_q[c][w] <= '0;
                    cnt_q[c][w] <= '0;
                end
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) acc_addr_q <= req_addr;
                end
                ST_LOOK_A, ST_LOOK_B: begin
                    cur_col_q <= m_col;
                    cur_way_q <= m_way;
                end
                ST_FILL: begin
                    if (cmd_ack) begin
                        vld_q[FAR_COL][vic_way[FAR_COL]] <= 1'b1;
                        tag_q[FAR_COL][vic_way[FAR_COL]] <= acc_addr_q;
                        cnt_q[FAR_COL][vic_way[FAR_COL]] <= '0;
                        cur_col_q <= FAR_COL;
                        cur_way_q <= vic_way[FAR_COL];
                    end
                end
                ST_BUMP_A, ST_BUMP_B: begin
                    if (cur_col_q != '0) begin
                        cnt_q[cur_col_q][cur_way_q] <= sat_next ? '0 : cur_cnt + 1'b1;
                    end
                end
                ST_MOVE_A, ST_MOVE_B: begin
                    if (cmd_ack) begin
                        vld_q[dst_col][dst_way]     <= vld_q[cur_col_q][cur_way_q];
                        tag_q[dst_col][dst_way]     <= tag_q[cur_col_q][cur_way_q];
                        cnt_q[dst_col][dst_way]     <= cnt_q[cur_col_q][cur_way_q];
                        vld_q[cur_col_q][cur_way_q] <= vld_q[dst_col][dst_way];
                        tag_q[cur_col_q][cur_way_q] <= tag_q[dst_col][dst_way];
                        cnt_q[cur_col_q][cur_way_q] <= cnt_q[dst_col][dst_way];
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/nm_mig_chk.sv
module nm_mig_chk #(
    parameter int COLS   = 8,
    parameter int ADDR_W = 16,
    localparam int COL_W = $clog2(COLS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cmd_valid,
    input logic              cmd_kind,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [COL_W-1:0]  cmd_src_col,
    input logic [COL_W-1:0]  cmd_dst_col,
    input logic              cmd_ack
);

    a_r1_idle_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_fill_far: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind) |-> (cmd_src_col == COL_W'(COLS - 1)) && (cmd_dst_col == COL_W'(COLS - 1)));

    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_kind) |-> (cmd_src_col == cmd_dst_col + 1'b1));

    a_r4_no_move_near: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_kind) |-> (cmd_src_col != '0));

    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ack) |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_addr)
                                    && $stable(cmd_src_col) && $stable(cmd_dst_col));

endmodule

bind nm_mig_ctrl nm_mig_chk #(
    .COLS   (COLS),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .cmd_addr    (cmd_addr),
    .cmd_src_col (cmd_src_col),
    .cmd_dst_col (cmd_dst_col),
    .cmd_ack     (cmd_ack)
);

// File: tb/sim_nm_mig_ctrl.sv
`timescale 1ns/1ps
module sim_nm_mig_ctrl;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          cmd_valid;
    logic          cmd_kind;
    logic [AW-1:0] cmd_addr;
    logic [2:0]    cmd_src_col;
    logic [2:0]    cmd_dst_col;
    logic          cmd_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic          kind;
        logic [AW-1:0] addr;
        logic [2:0]    src;
        logic [2:0]    dst;
        string         tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    nm_mig_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_ready   (req_ready),
        .cmd_valid   (cmd_valid),
        .cmd_kind    (cmd_kind),
        .cmd_addr    (cmd_addr),
        .cmd_src_col (cmd_src_col),
        .cmd_dst_col (cmd_dst_col),
        .cmd_ack     (cmd_ack)
    );

    task automatic expect_cmd(input logic k, input logic [AW-1:0] a,
                              input int s, input int d, input string tag);
        exp_t e;
        e.kind = k; e.addr = a; e.src = 3'(s); e.dst = 3'(d); e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (!(req_ready === 1'b1 && cmd_valid === 1'b0)) begin
            failures++;
            $display("FAIL R1 reset state: ready=%b valid=%b expected ready=1 valid=0", req_ready, cmd_valid);
        end
    endtask

    task automatic access(input logic [AW-1:0] a);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr  = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (req_ready !== 1'b0) begin
            failures++;
            $display("FAIL R1 busy after accept: ready=%b expected 0", req_ready);
        end
        while (!req_ready) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        repeat (6) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL %s missing commands: pending=%0d expected 0", tag, sb.size());
            sb.delete();
        end
    endtask

    // monitor: compare each command with the scoreboard, hold it, then ack
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid) begin
                logic          k0;
                logic [AW-1:0] a0;
                logic [2:0]    s0, d0;
                k0 = cmd_kind; a0 = cmd_addr; s0 = cmd_src_col; d0 = cmd_dst_col;
                checks++;
                if (sb.size() == 0) begin
                    failures++;
                    $display("FAIL R6 unexpected cmd: kind=%b addr=%h src=%0d dst=%0d expected none",
                             k0, a0, s0, d0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (k0 !== e.kind || a0 !== e.addr || s0 !== e.src || d0 !== e.dst) begin
                        failures++;
                        $display("FAIL %s cmd: kind=%b addr=%h src=%0d dst=%0d expected kind=%b addr=%h src=%0d dst=%0d",
                                 e.tag, k0, a0, s0, d0, e.kind, e.addr, e.src, e.dst);
                    end
                end
                repeat (2) @(negedge clk);
                checks++;
                if (!(cmd_valid === 1'b1 && cmd_kind === k0 && cmd_addr === a0 &&
                      cmd_src_col === s0 && cmd_dst_col === d0)) begin
                    failures++;
                    $display("FAIL R10 hold: valid=%b addr=%h expected valid=1 addr=%h", cmd_valid, cmd_addr, a0);
                end
                cmd_ack = 1'b1;
                @(negedge clk);
                cmd_ack = 1'b0;
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Scenario 1: fill, count to saturation, step inward to column 0, then stop (R2 R3 R4)
        do_reset();
        for (int i = 1; i <= 26; i++) begin
            if (i == 1) expect_cmd(1'b1, 16'h0010, 7, 7, "R2");
            if ((i % 3 == 0) && (i <= 21)) expect_cmd(1'b0, 16'h0010, 8 - i / 3, 7 - i / 3, "R3");
            access(16'h0010);
        end
        drain("R4");

        // Scenario 2: next block follows, absent next block not fetched (R5 R6)
        do_reset();
        expect_cmd(1'b1, 16'h0020, 7, 7, "R2");
        access(16'h0020);
        drain("R6");
        expect_cmd(1'b1, 16'h0021, 7, 7, "R2");
        access(16'h0021);
        access(16'h0020);
        expect_cmd(1'b0, 16'h0020, 7, 6, "R5");
        expect_cmd(1'b0, 16'h0021, 7, 6, "R5");
        access(16'h0020);
        drain("R5");

        // Scenario 3: next block already in column 0 is left alone (R4)
        do_reset();
        for (int i = 1; i <= 21; i++) begin
            if (i == 1) expect_cmd(1'b1, 16'h0041, 7, 7, "R2");
            if (i % 3 == 0) expect_cmd(1'b0, 16'h0041, 8 - i / 3, 7 - i / 3, "R3");
            access(16'h0041);
        end
        expect_cmd(1'b1, 16'h0040, 7, 7, "R2");
        expect_cmd(1'b0, 16'h0040, 7, 6, "R4");
        for (int i = 0; i < 3; i++) access(16'h0040);
        for (int i = 0; i < 4; i++) access(16'h0041);
        drain("R4");

        // Scenario 4: fill evicts least recently used way; hit refreshes recency (R7 R9)
        do_reset();
        expect_cmd(1'b1, 16'h0050, 7, 7, "R7");
        access(16'h0050);
        expect_cmd(1'b1, 16'h0060, 7, 7, "R7");
        access(16'h0060);
        access(16'h0050);
        expect_cmd(1'b1, 16'h0070, 7, 7, "R9");
        access(16'h0070);
        expect_cmd(1'b1, 16'h0060, 7, 7, "R9");
        access(16'h0060);
        expect_cmd(1'b1, 16'h0050, 7, 7, "R7");
        access(16'h0050);
        drain("R7");

        // Scenario 5: move victim stays resident one column out with its counter (R8)
        do_reset();
        expect_cmd(1'b1, 16'h0080, 7, 7, "R2");
        expect_cmd(1'b0, 16'h0080, 7, 6, "R3");
        for (int i = 0; i < 3; i++) access(16'h0080);
        expect_cmd(1'b1, 16'h0090, 7, 7, "R2");
        expect_cmd(1'b0, 16'h0090, 7, 6, "R3");
        for (int i = 0; i < 3; i++) access(16'h0090);
        expect_cmd(1'b1, 16'h00A0, 7, 7, "R2");
        expect_cmd(1'b0, 16'h00A0, 7, 6, "R8");
        for (int i = 0; i < 3; i++) access(16'h00A0);
        drain("R8");
        expect_cmd(1'b0, 16'h0080, 7, 6, "R8");
        for (int i = 0; i < 3; i++) access(16'h0080);
        drain("R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule